// File: doc/BRIEF.md
# Idle-Filtered Power-Down Request Controller

This block decides when a pair of serial channels may be powered down and applies the host's chosen power state to the logic around them. Each channel reports three flags: an interrupt-pending flag, a transmitter-idle flag and a receiver-idle flag. A channel is quiet when it has no pending interrupt and both of its directions are idle. When both channels are quiet at once, a filter timer starts. The timer length is picked by a 3-bit select. If both channels stay quiet until the timer expires, the block sets a power-down status bit. It can also raise a power-down interrupt. The filter stops bursty traffic from producing a stream of requests.

The block never changes the power state itself. The host writes a 2-bit power-state field, and the block decodes the value and holds it. In either low-power state the block does four things: it drops the clock enable to the channels, it masks interrupts, it refuses I/O and memory decode, and it arms a wake output. The wake output is gated by a separate enable bit. The configuration path is not gated by this block.

There are two state machines. The filter machine has four states:
- `FS_BUSY` (not jointly quiet).
- `FS_COUNT` (timer running).
- `FS_DONE` (request confirmed, status set).
- `FS_CLEARED` (software acknowledged, still quiet).

Its transitions are:
- BUSY→COUNT when both channels become quiet.
- COUNT→BUSY on any activity.
- COUNT→DONE when the timer expires.
- DONE→BUSY on activity.
- DONE→CLEARED on a clear strobe.
- CLEARED→BUSY on activity.

The power machine has three states: `PS_D0`, `PS_D2` and `PS_D3`. Any host write moves it to the decoded value of the written field. Without a write, it stays where it is.

Top module: `idle_pd_ctrl`

## Requirements
- R1: Channel i is quiet only when `ch_irq_pend[i]`=0, `ch_tx_idle[i]`=1 and `ch_rx_idle[i]`=1. The timer runs only while every channel is quiet, so one busy flag on either channel keeps `pd_status` at 0.
- R2: Let `filt_sel`=n. After both channels become quiet, `pd_status` rises on clock edge number 1 + 2^(n+4)·PRESCALE, counted from the first edge that sees them quiet. Before that edge it is 0. This covers n from 0 to 7, with PRESCALE=4 by default.
- R3: Any activity while the timer runs stops it. The next quiet period counts again from zero and needs the full time.
- R4: A confirmed request always sets `pd_status`. `pd_irq` is 1 only when `pd_status`=1, `pd_irq_en`=1 and the power state is D0.
- R5: `pd_status` stays at 1 until a `sts_clr` pulse or until activity. It is 0 on the edge that follows either event. After a clear, it stays 0 until activity has been seen and a full new quiet period has passed.
- R6: The power state changes only on a `pstate_wr` pulse. The field is decoded as 00 = D0, 10 = D2 and 11 = D3. A written 01 is taken as D0. `pstate` reads back the held code.
- R7: In D2 or D3, `ch_clk_en`=0 and `irq_mask`=1. `pd_irq`=0 even when enabled. In D0, `ch_clk_en`=1 and `irq_mask`=0.
- R8: `bar_en`=0 in D2 and D3, which refuses I/O and memory decode. `bar_en`=1 in D0.
- R9: `pme_o` sets on the edge after any channel is active while the state is D2 or D3 and `pme_en`=1. It stays set until `pme_en`=0 or the state is D0, and it never sets while `pme_en`=0.
- R10: After reset:
  - `pd_status`, `pd_irq`, `pme_o` and `irq_mask` are 0.
  - `pstate` is 00.
  - `ch_clk_en` and `bar_en` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_irq_pend | input | NUM_CH | Per-channel interrupt pending |
| ch_tx_idle | input | NUM_CH | Per-channel transmitter idle |
| ch_rx_idle | input | NUM_CH | Per-channel receiver idle |
| filt_sel | input | SEL_W | Filter time select |
| pd_irq_en | input | 1 | Power-down interrupt enable |
| sts_clr | input | 1 | Write-one-to-clear strobe for the status bit |
| pstate_wr | input | 1 | Host write strobe for the power-state field |
| pstate_wdata | input | 2 | Power-state value being written |
| pme_en | input | 1 | Wake output enable |
| pd_status | output | 1 | Confirmed power-down request |
| pd_irq | output | 1 | Power-down interrupt |
| ch_clk_en | output | 1 | Clock enable to the serial channels |
| irq_mask | output | 1 | Mask for all interrupts of the function |
| bar_en | output | 1 | I/O and memory decode enable |
| pstate | output | 2 | Held power-state code |
| pme_o | output | 1 | Wake request |

## Verification
The assertions check four rules on every cycle:
- Activity always clears the status bit on the next edge.
- A new quiet period always starts counting from zero.
- The acknowledged state never re-arms without activity, and the power state never moves without a write.
- The low-power gates move together, and the wake output falls once its enable drops.

Only the bench scenarios can show the exact expiry edge for several select values, including the longest one. The same goes for each per-channel flag blocking the request, the interrupt-enable split, the 01 decode, and the wake sequence through D2 and back to D0.

// File: rtl/idle_pd_pkg.sv
package idle_pd_pkg;

    // Filter state machine
    typedef enum logic [1:0] {
        FS_BUSY    = 2'd0,
        FS_COUNT   = 2'd1,
        FS_DONE    = 2'd2,
        FS_CLEARED = 2'd3
    } filt_state_t;

    // Power states; the code is what the host writes and reads back
    typedef enum logic [1:0] {
        PS_D0 = 2'b00,
        PS_D2 = 2'b10,
        PS_D3 = 2'b11
    } pwr_state_t;

    // Unsupported codes fall back to D0
    function automatic pwr_state_t decode_pstate(input logic [1:0] code);
        unique case (code)
            2'b10:   return PS_D2;
            2'b11:   return PS_D3;
            default: return PS_D0;
        endcase
    endfunction

endpackage

// File: rtl/idle_pd_prescaler.sv
module idle_pd_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    generate
        if (PRESCALE <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_div
            localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);
            logic [PRE_W-1:0] div_q;

            // Phase restarts whenever the timer is not running
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    div_q <= '0;
                end else if (div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + PRE_W'(1);
                end
            end

            assign tick = run && (div_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/idle_pd_filter.sv
module idle_pd_filter
    import idle_pd_pkg::*;
#(
    parameter int SEL_W    = 3,
    parameter int BASE_EXP = 4,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             joint_idle,
    input  logic [SEL_W-1:0] filt_sel,
    input  logic             sts_clr,
    output logic             pd_status
);
    // Widest period is 2^(BASE_EXP + 2^SEL_W - 1) ticks
    localparam int CNT_W = BASE_EXP + (1 << SEL_W) - 1;

    filt_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period_m1;
    logic [CNT_W:0]   one_sh;
    logic [7:0]       shamt;
    logic             tick;
    logic             expire;

    idle_pd_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == FS_COUNT),
        .tick (tick)
    );

    // Period in ticks minus one, from the select field
    always_comb begin
        shamt     = 8'(filt_sel) + 8'(BASE_EXP);
        one_sh    = (CNT_W+1)'(1) << shamt;
        period_m1 = CNT_W'(one_sh - (CNT_W+1)'(1));
    end

    assign expire = tick && (cnt_q == period_m1);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_BUSY:    if (joint_idle) state_d = FS_COUNT;
            FS_COUNT:   if (!joint_idle) state_d = FS_BUSY;
                        else if (expire) state_d = FS_DONE;
            FS_DONE:    if (!joint_idle) state_d = FS_BUSY;
                        else if (sts_clr) state_d = FS_CLEARED;
            FS_CLEARED: if (!joint_idle) state_d = FS_BUSY;
            default:    state_d = FS_BUSY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_BUSY;
        else        state_q <= state_d;
    end

    // Tick counter, cleared outside the counting state
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != FS_COUNT) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Outputs
    always_comb begin
        pd_status = (state_q == FS_DONE);
    end

    // R5: activity always drops the status on the next edge
    p_activity_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !joint_idle |=> !pd_status);

    // R3: a new quiet period counts from zero
    p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_BUSY && joint_idle) |=> (state_q == FS_COUNT && cnt_q == '0));

    // R5: the acknowledged state never re-raises while still quiet
    p_no_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_CLEARED && joint_idle) |=> !pd_status);

endmodule

// File: rtl/idle_pd_power.sv
module idle_pd_power
    import idle_pd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pstate_wr,
    input  logic [1:0] pstate_wdata,
    input  logic       pme_en,
    input  logic       any_active,
    output logic [1:0] pstate,
    output logic       low_pwr,
    output logic       pme_o
);
    pwr_state_t state_q, state_d;
    logic       pme_q, pme_d;

    // Next-state logic: only host writes move the state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_D0, PS_D2, PS_D3: if (pstate_wr) state_d = decode_pstate(pstate_wdata);
            default:             state_d = PS_D0;
        endcase
    end

    // Wake request: arms in low power on activity, gated by its enable
    always_comb begin
        pme_d = pme_q;
        if (!pme_en || state_q == PS_D0) pme_d = 1'b0;
        else if (any_active)             pme_d = 1'b1;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_D0;
            pme_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pme_q   <= pme_d;
        end
    end

    // Outputs
    always_comb begin
        pstate  = state_q;
        low_pwr = (state_q != PS_D0);
        pme_o   = pme_q;
    end

    // R6: no write, no state change
    p_state_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pstate_wr |=> $stable(state_q));

    // R9: wake output falls once its enable is low
    p_pme_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pme_en |=> !pme_o);

endmodule

// File: rtl/idle_pd_ctrl.sv
module idle_pd_ctrl
    import idle_pd_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int SEL_W    = 3,
    parameter int BASE_EXP = 4,
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_irq_pend,
    input  logic [NUM_CH-1:0] ch_tx_idle,
    input  logic [NUM_CH-1:0] ch_rx_idle,
    input  logic [SEL_W-1:0]  filt_sel,
    input  logic              pd_irq_en,
    input  logic              sts_clr,
    input  logic              pstate_wr,
    input  logic [1:0]        pstate_wdata,
    input  logic              pme_en,
    output logic              pd_status,
    output logic              pd_irq,
    output logic              ch_clk_en,
    output logic              irq_mask,
    output logic              bar_en,
    output logic [1:0]        pstate,
    output logic              pme_o
);
    logic [NUM_CH-1:0] ch_quiet;
    logic              joint_idle;
    logic              low_pwr;

    // Per-channel quiet detection
    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            assign ch_quiet[i] = !ch_irq_pend[i] && ch_tx_idle[i] && ch_rx_idle[i];
        end
    endgenerate

    assign joint_idle = &ch_quiet;

    idle_pd_filter #(
        .SEL_W   (SEL_W),
        .BASE_EXP(BASE_EXP),
        .PRESCALE(PRESCALE)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .joint_idle(joint_idle),
        .filt_sel  (filt_sel),
        .sts_clr   (sts_clr),
        .pd_status (pd_status)
    );

    idle_pd_power u_power (
        .clk         (clk),
        .rst_n       (rst_n),
        .pstate_wr   (pstate_wr),
        .pstate_wdata(pstate_wdata),
        .pme_en      (pme_en),
        .any_active  (!joint_idle),
        .pstate      (pstate),
        .low_pwr     (low_pwr),
        .pme_o       (pme_o)
    );

    // Low-power gating of clock, interrupts and decode
    always_comb begin
        ch_clk_en = !low_pwr;
        irq_mask  = low_pwr;
        bar_en    = !low_pwr;
        pd_irq    = pd_status && pd_irq_en && !low_pwr;
    end

    // R7/R8: all low-power gates move together
    p_lowpwr_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_clk_en |-> (irq_mask && !bar_en && !pd_irq));

endmodule

// File: tb/tb_idle_pd_ctrl.sv
module tb_idle_pd_ctrl;
    localparam int PRESCALE = 4;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [1:0] ch_irq_pend = '0, ch_tx_idle = '1, ch_rx_idle = '1;
    logic [2:0] filt_sel = '0;
    logic       pd_irq_en = 0, sts_clr = 0, pstate_wr = 0, pme_en = 0;
    logic [1:0] pstate_wdata = '0;
    logic       pd_status, pd_irq, ch_clk_en, irq_mask, bar_en, pme_o;
    logic [1:0] pstate;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    idle_pd_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .ch_irq_pend(ch_irq_pend), .ch_tx_idle(ch_tx_idle), .ch_rx_idle(ch_rx_idle),
        .filt_sel(filt_sel), .pd_irq_en(pd_irq_en), .sts_clr(sts_clr),
        .pstate_wr(pstate_wr), .pstate_wdata(pstate_wdata), .pme_en(pme_en),
        .pd_status(pd_status), .pd_irq(pd_irq), .ch_clk_en(ch_clk_en),
        .irq_mask(irq_mask), .bar_en(bar_en), .pstate(pstate), .pme_o(pme_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int period_cycles(input int sel);
        return (1 << (sel + 4)) * PRESCALE;
    endfunction

    // Make both channels busy for one cycle, then quiet again
    task automatic blip();
        ch_irq_pend = 2'b01; cyc(1);
        ch_irq_pend = 2'b00;
    endtask

    task automatic write_ps(input logic [1:0] v);
        pstate_wr = 1; pstate_wdata = v; cyc(1);
        pstate_wr = 0;
    endtask

    task automatic t_reset();
        check("R10 pd_status", pd_status, 0);
        check("R10 pd_irq", pd_irq, 0);
        check("R10 pme_o", pme_o, 0);
        check("R10 irq_mask", irq_mask, 0);
        check("R10 pstate", pstate, 0);
        check("R10 ch_clk_en", ch_clk_en, 1);
        check("R10 bar_en", bar_en, 1);
    endtask

    // R2: exact expiry edge for a given select
    task automatic t_period(input int sel);
        filt_sel = 3'(sel);
        blip();
        cyc(period_cycles(sel));
        check($sformatf("R2 sel=%0d before", sel), pd_status, 0);
        cyc(1);
        check($sformatf("R2 sel=%0d at", sel), pd_status, 1);
    endtask

    // R3: a blip mid-period restarts the count
    task automatic t_cancel();
        filt_sel = 0;
        blip();
        cyc(40);
        blip();
        cyc(period_cycles(0));
        check("R3 restart before", pd_status, 0);
        cyc(1);
        check("R3 restart at", pd_status, 1);
    endtask

    // R1: each busy flag alone blocks the request
    task automatic t_channel_flags();
        filt_sel = 0;
        ch_irq_pend = 2'b10; cyc(100);
        check("R1 irq pending ch1", pd_status, 0);
        ch_irq_pend = 2'b00; ch_tx_idle = 2'b10; cyc(100);
        check("R1 tx busy ch0", pd_status, 0);
        ch_tx_idle = 2'b11; ch_rx_idle = 2'b01; cyc(100);
        check("R1 rx busy ch1", pd_status, 0);
        ch_rx_idle = 2'b11;
    endtask

    // R4/R5: interrupt enable split, clear, re-arm, activity clear
    task automatic t_irq_and_clear();
        filt_sel = 0;
        pd_irq_en = 0;
        blip();
        cyc(period_cycles(0) + 1);
        check("R4 status without enable", pd_status, 1);
        check("R4 irq without enable", pd_irq, 0);
        pd_irq_en = 1; #1;
        check("R4 irq with enable", pd_irq, 1);
        cyc(50);
        check("R5 status held", pd_status, 1);
        sts_clr = 1; cyc(1); sts_clr = 0;
        check("R5 cleared by W1C", pd_status, 0);
        cyc(300);
        check("R5 no rearm while quiet", pd_status, 0);
        blip();
        cyc(period_cycles(0) + 1);
        check("R5 rearm after activity", pd_status, 1);
        ch_tx_idle = 2'b01; cyc(1);
        check("R5 activity clears status", pd_status, 0);
        check("R5 activity clears irq", pd_irq, 0);
        ch_tx_idle = 2'b11;
        pd_irq_en = 0;
    endtask

    // R6/R7/R8: decode, hold and low-power gating
    task automatic t_power();
        filt_sel = 0; pd_irq_en = 1;
        blip();
        cyc(period_cycles(0) + 1);
        check("R4 irq in D0", pd_irq, 1);
        write_ps(2'b11);
        check("R6 D3 code", pstate, 3);
        check("R7 clk off D3", ch_clk_en, 0);
        check("R7 mask D3", irq_mask, 1);
        check("R7 irq masked D3", pd_irq, 0);
        check("R8 bar off D3", bar_en, 0);
        check("R4 status still visible", pd_status, 1);
        blip(); cyc(100);
        check("R6 state held without write", pstate, 3);
        write_ps(2'b01);
        check("R6 code 01 taken as D0", pstate, 0);
        check("R7 clk on D0", ch_clk_en, 1);
        check("R8 bar on D0", bar_en, 1);
        write_ps(2'b10);
        check("R6 D2 code", pstate, 2);
        check("R8 bar off D2", bar_en, 0);
        check("R7 mask D2", irq_mask, 1);
        write_ps(2'b00);
        check("R6 D0 code", pstate, 0);
        pd_irq_en = 0;
    endtask

    // R9: wake output gating and hold
    task automatic t_wake();
        write_ps(2'b10);
        pme_en = 0;
        blip(); cyc(1);
        check("R9 no wake without enable", pme_o, 0);
        pme_en = 1; cyc(3);
        check("R9 no wake while quiet", pme_o, 0);
        ch_rx_idle = 2'b10; cyc(1);
        check("R9 wake on activity", pme_o, 1);
        ch_rx_idle = 2'b11; cyc(5);
        check("R9 wake held", pme_o, 1);
        pme_en = 0; cyc(1);
        check("R9 wake dropped by enable", pme_o, 0);
        pme_en = 1; blip(); cyc(1);
        check("R9 wake rearmed", pme_o, 1);
        write_ps(2'b00); cyc(1);
        check("R9 wake cleared in D0", pme_o, 0);
        blip(); cyc(1);
        check("R9 no wake in D0", pme_o, 0);
        pme_en = 0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        t_reset();
        t_period(0);
        t_period(2);
        t_period(7);
        t_cancel();
        t_channel_flags();
        t_irq_and_clear();
        t_power();
        t_wake();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule